// File: doc/BRIEF.md
# Six-Pin Microcontroller I/O Port

This block is the general-purpose I/O port of a small 8-bit microcontroller core. The core writes the port's output data latch with an ordinary register write. It loads a separate direction latch from its working register with a dedicated instruction strobe. The direction latch cannot be read back. A port read always returns the present pad levels, masked by configuration. It never returns the latch contents.

Six pins are implemented, and the upper two bits of the 8-bit port read as zero. Configuration arrives on static inputs:
- Pin 3 is input only.
- Pin 2's driver can be turned off by an option-register bit.
- Any pin given to an alternate function reads as zero.
- Pins 0, 1 and 3 share a single weak pull-up enable and a single wake-on-change enable.
- When pin 3 serves as the reset input, its pull-up is forced on and it takes no part in wake-on-change.

Each port read captures the wake-group levels. While wake-on-change is enabled, any later difference sets a sticky wake flag.

Top module: `gpio6_port`

## Requirements
- R1: After reset, every pad output enable is 0 (all pins are inputs), the output latch value is 0 and the wake flag is 0.
- R2: `rd_data_o` bits 7:6 are always 0, and bits 5:0 equal the present `pad_in_i` levels, combinationally, whatever the output latch holds.
- R3: A direction bit of 0 enables that pin's driver and a 1 disables it. The direction latch takes `wreg_i[5:0]` at the edge where `dir_we_i` is high and holds otherwise, so the enables change one cycle after the strobe.
- R4: Pin 3's output enable (`pad_oe_o[3]`) is never 1, whatever its direction bit.
- R5: While `opt_p2_off_i` is 1, `pad_oe_o[2]` is 0 regardless of direction bit 2.
- R6: A pin whose `alt_fn_i` bit is 1 reads as 0 in `rd_data_o`.
- R7: `pad_out_o` shows the output latch, which takes `wreg_i[5:0]` at the edge where `port_we_i` is high and keeps its value otherwise.
- R8: `pad_pu_o` bits 0, 1 and 3 all equal `pu_en_i`, and bits 2, 4 and 5 are 0, unless R9 applies.
- R9: While `rst_pin_mode_i` is 1, `pad_pu_o[3]` is 1 and a change on pin 3 never sets the wake flag.
- R10: Each `port_re_i` cycle captures the pad levels. At a later edge where `port_re_i` is low, `wake_en_i` is 1, and an enabled wake pin (0, 1, or 3 when not in reset mode) differs from its captured level, `wake_o` becomes 1. It then stays 1 until reset. With no capture since reset, it never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wreg_i | input | 8 | Working register value from the core |
| port_we_i | input | 1 | Write strobe for the output data latch |
| dir_we_i | input | 1 | Load strobe for the direction latch |
| port_re_i | input | 1 | Port read strobe (captures the wake reference) |
| rd_data_o | output | 8 | Port read value |
| pad_in_i | input | 6 | Pad input levels |
| pad_out_o | output | 6 | Pad driver data |
| pad_oe_o | output | 6 | Pad driver enables, 1 = driving |
| pad_pu_o | output | 6 | Weak pull-up enables |
| alt_fn_i | input | 6 | Alternate-function pin mask |
| pu_en_i | input | 1 | Group weak pull-up enable |
| wake_en_i | input | 1 | Group wake-on-change enable |
| rst_pin_mode_i | input | 1 | Pin 3 acts as the reset input |
| opt_p2_off_i | input | 1 | Option bit that turns off pin 2's driver |
| wake_o | output | 1 | Sticky wake flag |

## Verification
Several results are due in the same cycle as their stimulus. The read value, the pull-up enables and the pin 2 and pin 3 driver masking follow their inputs combinationally, so the bench compares them 1 ns after driving the inputs and before the next edge. The direction latch, the data latch and the wake flag change only at the clock edge after a strobe or a mismatch. The bench's reference model updates its state at that same edge, so the registered outputs are first compared in the following cycle. The comparisons run every cycle, so a result that arrives a cycle early or late is reported.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
    localparam int PIN_N = 6;
    localparam int REG_W = 8;
    typedef logic [PIN_N-1:0] pins_t;
endpackage

// File: rtl/gpio6_latch_bank.sv
module gpio6_latch_bank
    import gpio6_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t wdata_i,
    input  logic  data_we_i,
    input  logic  dir_we_i,
    output pins_t data_q_o,
    output pins_t dir_q_o
);
    typedef struct packed {
        pins_t data;
        pins_t dir;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (data_we_i) st_d.data = wdata_i;
        if (dir_we_i)  st_d.dir  = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data <= '0;
            st_q.dir  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q_o = st_q.data;
    assign dir_q_o  = st_q.dir;

    a_r3_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_we_i |=> $stable(st_q.dir));
    a_r3_dir_loads: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we_i |=> st_q.dir == $past(wdata_i));
    a_r7_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !data_we_i |=> $stable(st_q.data));
endmodule

// File: rtl/gpio6_drive.sv
module gpio6_drive
    import gpio6_pkg::*;
#(
    parameter int    IN_ONLY_PIN = 3,
    parameter int    OVR_PIN     = 2,
    parameter int    RST_PIN     = 3,
    parameter pins_t GROUP_MASK  = 6'b001011
) (
    input  pins_t dir_i,
    input  logic  ovr_off_i,
    input  logic  pu_en_i,
    input  logic  rst_mode_i,
    output pins_t oe_o,
    output pins_t pu_o
);
    always_comb begin
        for (int i = 0; i < PIN_N; i++) begin
            oe_o[i] = ~dir_i[i];
            if (i == IN_ONLY_PIN) oe_o[i] = 1'b0;
            if (i == OVR_PIN && ovr_off_i) oe_o[i] = 1'b0;
            pu_o[i] = pu_en_i & GROUP_MASK[i];
            if (i == RST_PIN && rst_mode_i) pu_o[i] = 1'b1;
        end
    end

    always_comb begin
        a_r4_in_only_quiet: assert (oe_o[IN_ONLY_PIN] == 1'b0);
        if (rst_mode_i) a_r9_rst_pullup: assert (pu_o[RST_PIN]);
    end
endmodule

// File: rtl/gpio6_wake.sv
module gpio6_wake
    import gpio6_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pad_i,
    input  pins_t mask_i,
    input  logic  en_i,
    input  logic  rd_stb_i,
    output logic  wake_o
);
    typedef struct packed {
        pins_t snap;
        logic  armed;
        logic  wake;
    } wk_t;

    wk_t st_d, st_q;
    logic diff;

    assign diff = |((pad_i ^ st_q.snap) & mask_i);

    always_comb begin
        st_d = st_q;
        if (rd_stb_i) begin
            st_d.snap  = pad_i;
            st_d.armed = 1'b1;
        end else if (st_q.armed && en_i && diff) begin
            st_d.wake = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake_o = st_q.wake;

    a_r10_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |=> st_q.wake);
    a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !st_q.wake) |=> !st_q.wake);
    a_r10_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> !st_q.wake);
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
    import gpio6_pkg::*;
#(
    parameter int    IN_ONLY_PIN = 3,
    parameter int    OVR_PIN     = 2,
    parameter int    RST_PIN     = 3,
    parameter pins_t GROUP_MASK  = 6'b001011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] wreg_i,
    input  logic             port_we_i,
    input  logic             dir_we_i,
    input  logic             port_re_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic [PIN_N-1:0] pad_in_i,
    output logic [PIN_N-1:0] pad_out_o,
    output logic [PIN_N-1:0] pad_oe_o,
    output logic [PIN_N-1:0] pad_pu_o,
    input  logic [PIN_N-1:0] alt_fn_i,
    input  logic             pu_en_i,
    input  logic             wake_en_i,
    input  logic             rst_pin_mode_i,
    input  logic             opt_p2_off_i,
    output logic             wake_o
);
    localparam pins_t RST_BIT = pins_t'(1) << RST_PIN;

    pins_t dir_q, wake_mask;
    logic  unused_hi;

    assign unused_hi = ^wreg_i[REG_W-1:PIN_N];

    gpio6_latch_bank u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata_i   (wreg_i[PIN_N-1:0]),
        .data_we_i (port_we_i),
        .dir_we_i  (dir_we_i),
        .data_q_o  (pad_out_o),
        .dir_q_o   (dir_q)
    );

    gpio6_drive #(
        .IN_ONLY_PIN (IN_ONLY_PIN),
        .OVR_PIN     (OVR_PIN),
        .RST_PIN     (RST_PIN),
        .GROUP_MASK  (GROUP_MASK)
    ) u_drv (
        .dir_i      (dir_q),
        .ovr_off_i  (opt_p2_off_i),
        .pu_en_i    (pu_en_i),
        .rst_mode_i (rst_pin_mode_i),
        .oe_o       (pad_oe_o),
        .pu_o       (pad_pu_o)
    );

    assign wake_mask = rst_pin_mode_i ? (GROUP_MASK & ~RST_BIT) : GROUP_MASK;

    gpio6_wake u_wk (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_i    (pad_in_i),
        .mask_i   (wake_mask),
        .en_i     (wake_en_i),
        .rd_stb_i (port_re_i),
        .wake_o   (wake_o)
    );

    assign rd_data_o = {{(REG_W-PIN_N){1'b0}}, pad_in_i & ~alt_fn_i};

    a_r5_ovr_off: assert property (@(posedge clk) disable iff (!rst_n)
        opt_p2_off_i |-> !pad_oe_o[OVR_PIN]);
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[REG_W-1:PIN_N] == '0);
endmodule

// File: tb/tb_gpio6_port.sv
module tb_gpio6_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wreg = '0;
    logic       port_we = 0, dir_we = 0, port_re = 0;
    logic [7:0] rd_data;
    logic [5:0] pad_in = '0, pad_out, pad_oe, pad_pu, alt_fn = '0;
    logic       pu_en = 0, wake_en = 0, rst_mode = 0, p2_off = 0, wake;

    int vectors = 0, miscompares = 0;
    int m_dir, m_data, m_snap, m_armed, m_wake;

    always #10 clk = ~clk;

    gpio6_port dut (
        .clk(clk), .rst_n(rst_n), .wreg_i(wreg), .port_we_i(port_we),
        .dir_we_i(dir_we), .port_re_i(port_re), .rd_data_o(rd_data),
        .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .pad_pu_o(pad_pu), .alt_fn_i(alt_fn), .pu_en_i(pu_en),
        .wake_en_i(wake_en), .rst_pin_mode_i(rst_mode),
        .opt_p2_off_i(p2_off), .wake_o(wake)
    );

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int e_oe, e_pu, e_rd, wmask;
        e_oe = (~m_dir) & 6'h3F;
        e_oe &= ~(1 << 3);
        if (p2_off) e_oe &= ~(1 << 2);
        e_pu = pu_en ? 6'b001011 : 0;
        if (rst_mode) e_pu |= (1 << 3);
        e_rd = pad_in & ~alt_fn;
        chk("R2/R6 rd_data", rd_data, e_rd);
        chk("R1/R3/R4/R5 pad_oe", pad_oe, e_oe);
        chk("R7 pad_out", pad_out, m_data);
        chk("R8/R9 pad_pu", pad_pu, e_pu);
        chk("R10 wake", wake, m_wake);
        wmask = 6'b001011;
        if (rst_mode) wmask &= ~(1 << 3);
        // R9: wake mask excludes pin 3 in reset mode (used in model below)
        @(posedge clk);
        if (port_re) begin
            m_snap = pad_in; m_armed = 1;
        end else if (m_armed != 0 && wake_en && (((pad_in ^ m_snap) & wmask) != 0)) begin
            m_wake = 1;
        end
        if (port_we) m_data = wreg[5:0];
        if (dir_we)  m_dir  = wreg[5:0];
        @(negedge clk);
    endtask

    task automatic step();
        #1 compare_all();
        port_we = 0; dir_we = 0; port_re = 0;
    endtask

    initial begin
        m_dir = 6'h3F; m_data = 0; m_snap = 0; m_armed = 0; m_wake = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        step();
        // R2: reads follow pads, bits 7:6 zero
        for (int p = 0; p < 64; p += 13) begin pad_in = p[5:0]; step(); end
        // R7: data latch write, then hold
        wreg = 8'hEA; port_we = 1; step();
        wreg = 8'h15; step(); step();
        // R3: direction load, all outputs; R4 pin 3 stays off
        wreg = 8'hC0; dir_we = 1; step(); step();
        // R2: latch drives high but pad held low reads 0
        pad_in = 6'h00; step();
        // R5: pin 2 override
        p2_off = 1; step(); p2_off = 0; step();
        wreg = 8'h2B; dir_we = 1; step(); p2_off = 1; step(); p2_off = 0;
        // R6: alternate function masking
        pad_in = 6'h3F; alt_fn = 6'b100100; step(); alt_fn = 6'h3F; step(); alt_fn = 0;
        // R8/R9: pull-ups
        pu_en = 1; step(); rst_mode = 1; step(); pu_en = 0; step(); rst_mode = 0; step();
        // R10: no capture yet, enabled, pads changing: no wake
        wake_en = 1; pad_in = 6'h00; step(); pad_in = 6'h3F; step();
        // capture, change non-group pin: no wake
        port_re = 1; step(); pad_in = 6'b011111; step(); pad_in = 6'h3F; step();
        // R9: pin 3 change in reset mode ignored
        rst_mode = 1; pad_in = 6'b110111; step(); step();
        rst_mode = 0; pad_in = 6'h3F; step();
        // wake disabled while pin 1 differs: no wake
        wake_en = 0; pad_in = 6'b111101; step(); step();
        // re-read recaptures: no wake after enabling
        port_re = 1; step(); wake_en = 1; step();
        // change pin 0 -> wake, then sticky
        pad_in = 6'b111100; step(); pad_in = 6'b111101; step(); wake_en = 0; step(); step();
        // R1: reset clears wake and direction
        rst_n = 0; m_dir = 6'h3F; m_data = 0; m_snap = 0; m_armed = 0; m_wake = 0;
        @(negedge clk); rst_n = 1; step(); step();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #2000000;
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule